// File: doc/BRIEF.md
# Scanner Start and Pause Sequencer

This block keeps a sensing front end in step with an external scanner. A single-phase clock drives it. When the scanner pulls the start input low, the block waits a fixed number of rising edges. It then raises the sensor gate output and holds it high for a set number of clock cycles, which is the window in which a photodiode is being read. A counter shows the position inside that window.

The scanner can also halt the sequencing for short pauses, under 100 ms. It raises a strobe for one cycle and presents the pause level in the following cycle. The block takes the pause level only in that cycle and ignores it at all other times. The freeze output changes on the falling clock edge, half a cycle after the rising edge that took the sample. While freeze is high, the state, the gate and the counter keep their values. A start falling edge that arrives while frozen is remembered and acted on once the freeze ends.

The block also decodes three static test-control levels into flags. Start, pause and strobe each pass through a two-flop synchronizer before use.

The sequencer has three states:
- **IDLE**: the gate is low and the block waits.
- **ARM**: the one-cycle wait before the gate opens.
- **SENSE**: the gate is high.

It has three transitions:
- **IDLE→ARM** happens when a start fall, fresh or remembered, is seen while not frozen.
- **ARM→SENSE** happens on the next unfrozen edge.
- **SENSE→IDLE** happens on the unfrozen edge at which the counter is at its last value.

Any state stays where it is while freeze is high.

Top module: `scan_sync_ctrl`

## Requirements
- R1: If start_in was high and is first sampled low at rising edge k, sense_gate goes high just after rising edge k+3, and seq_count reads 0 at that point.
- R2: With no freeze, sense_gate stays high for GATE_CYCLES (default 8) rising edges. After edge k+3+i, seq_count reads i. sense_gate is low and seq_count is 0 after edge k+3+GATE_CYCLES.
- R3: A start_in fall that is seen while the gate sequence is active and not frozen is ignored. No second gate window follows. A rising start_in has no effect.
- R4: If pause_strobe is first sampled high at rising edge j, the pause_in level at edge j+1 is taken. If that level is high, freeze rises at the falling edge after edge j+3 and is still low just after edge j+3.
- R5: pause_in changes that are not qualified by a strobe have no effect on freeze.
- R6: A strobe-qualified low pause level makes freeze fall at the falling edge after edge j+3, with the same timing as R4.
- R7: While freeze is high, sense_gate and seq_count hold their values. Counting resumes on the first rising edge after freeze falls.
- R8: A start_in fall seen while frozen in IDLE is held. If freeze falls after rising edge r, sense_gate rises just after edge r+2.
- R9: test_active = NOT test_ctl[0]. lin_test = test_active AND test_ctl[1]. unif_test = test_active AND test_ctl[2]. All three are low in normal operation (test_ctl[0] high).
- R10: While rst_n is low, sense_gate, freeze and seq_count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Scanner start; a falling edge begins a gate window |
| pause_in | input | 1 | Pause level, valid in the cycle after a strobe |
| pause_strobe | input | 1 | One-cycle pulse that qualifies pause_in |
| test_ctl | input | 3 | Test controls: bit 0 high means normal, bit 1 linearity, bit 2 uniformity |
| sense_gate | output | 1 | High while a photodiode is being sensed |
| freeze | output | 1 | Sequencing halted; changes on the falling edge |
| seq_count | output | CNT_W | Position inside the gate window |
| test_active | output | 1 | Test mode selected |
| lin_test | output | 1 | Linearity test selected |
| unif_test | output | 1 | Uniformity test selected |

## Verification
A state register stuck or skipping ARM shows at sense_gate within one cycle of the expected rise at edge k+3. A miscounting window shows in seq_count on the very next edge and in the gate's fall edge. A freeze captured outside the strobe cycle, or clocked on the rising edge, shows as a freeze change half a cycle early or late. That is caught by sampling both just after the rising edge and just after the falling edge. A lost remembered start shows as no gate at all two edges after release.

// File: rtl/scan_sync_pkg.sv
package scan_sync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SENSE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sync2.sv
module sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pause_qualifier.sv
module pause_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_s,
    input  logic pause_s,
    output logic freeze
);
    logic strobe_q;
    logic pause_req;

    // strobe_q marks the cycle after the strobe: the only cycle pause is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q  <= 1'b0;
            pause_req <= 1'b0;
        end else begin
            strobe_q <= strobe_s;
            if (strobe_q) begin
                pause_req <= pause_s;
            end
        end
    end

    // half-cycle retiming: freeze moves on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freeze <= 1'b0;
        end else begin
            freeze <= pause_req;
        end
    end
endmodule

// File: rtl/start_detect.sv
module start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic start_s,
    input  logic freeze,
    input  logic consume,
    output logic start_go
);
    logic start_prev;
    logic pending;
    logic fall;

    assign fall     = start_prev & ~start_s;
    assign start_go = fall | pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_prev <= 1'b0;
            pending    <= 1'b0;
        end else begin
            start_prev <= start_s;
            if (consume) begin
                pending <= 1'b0;
            end else if (fall && freeze) begin
                pending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/test_decode.sv
module test_decode (
    input  logic [2:0] test_ctl,
    output logic       test_active,
    output logic       lin_test,
    output logic       unif_test
);
    always_comb begin
        test_active = ~test_ctl[0];
        lin_test    = ~test_ctl[0] & test_ctl[1];
        unif_test   = ~test_ctl[0] & test_ctl[2];
    end
endmodule

// File: rtl/scan_sync_ctrl.sv
module scan_sync_ctrl
    import scan_sync_pkg::*;
#(
    parameter int GATE_CYCLES = 8,
    parameter int CNT_W       = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_in,
    input  logic             pause_in,
    input  logic             pause_strobe,
    input  logic [2:0]       test_ctl,
    output logic             sense_gate,
    output logic             freeze,
    output logic [CNT_W-1:0] seq_count,
    output logic             test_active,
    output logic             lin_test,
    output logic             unif_test
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GATE_CYCLES - 1);

    logic [2:0]       raw_in;
    logic [2:0]       syn_in;
    logic             start_go;
    logic             consume;
    seq_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    assign raw_in = {start_in, pause_in, pause_strobe};

    sync2 #(.WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    pause_qualifier u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (syn_in[0]),
        .pause_s  (syn_in[1]),
        .freeze   (freeze)
    );

    start_detect u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_s  (syn_in[2]),
        .freeze   (freeze),
        .consume  (consume),
        .start_go (start_go)
    );

    test_decode u_test (
        .test_ctl    (test_ctl),
        .test_active (test_active),
        .lin_test    (lin_test),
        .unif_test   (unif_test)
    );

    assign consume = (state == ST_IDLE) && !freeze && start_go;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (!freeze && start_go) begin
                    state_nxt = ST_ARM;
                end
            end
            ST_ARM: begin
                if (!freeze) begin
                    state_nxt = ST_SENSE;
                end
            end
            ST_SENSE: begin
                if (!freeze) begin
                    if (cnt == LAST) begin
                        state_nxt = ST_IDLE;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        sense_gate = (state == ST_SENSE);
        seq_count  = cnt;
    end
endmodule

// File: rtl/scan_sync_ctrl_chk.sv
module scan_sync_ctrl_chk #(
    parameter int GATE_CYCLES = 8,
    parameter int CNT_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             freeze,
    input logic             sense_gate,
    input logic [CNT_W-1:0] seq_count,
    input logic             test_active,
    input logic             lin_test,
    input logic             unif_test
);
    logic past_ok;
    int   run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            run_len <= 0;
        end else begin
            past_ok <= 1'b1;
            if (!sense_gate) begin
                run_len <= 0;
            end else if (!freeze) begin
                run_len <= run_len + 1;
            end
        end
    end

    assert_gate_opens_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(sense_gate)) |-> (seq_count == '0));

    assert_gate_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_len <= GATE_CYCLES) && (int'(seq_count) < GATE_CYCLES));

    assert_hold_when_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(freeze)) |-> ($stable(seq_count) && $stable(sense_gate)));

    always_comb begin
        assert_decode_normal_R9: assert (test_active || (!lin_test && !unif_test));
    end
endmodule

bind scan_sync_ctrl scan_sync_ctrl_chk #(
    .GATE_CYCLES (GATE_CYCLES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze      (freeze),
    .sense_gate  (sense_gate),
    .seq_count   (seq_count),
    .test_active (test_active),
    .lin_test    (lin_test),
    .unif_test   (unif_test)
);

// File: tb/scan_sync_ctrl_bench.sv
module scan_sync_ctrl_bench;
    localparam int GATE = 8;
    localparam int CW   = 3;

    // {test_ctl[2:0], test_active, lin_test, unif_test}
    localparam logic [5:0] DEC_TAB [8] = '{
        6'b000_100, 6'b001_000, 6'b010_110, 6'b011_000,
        6'b100_101, 6'b101_000, 6'b110_111, 6'b111_000
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_in;
    logic          pause_in;
    logic          pause_strobe;
    logic [2:0]    test_ctl;
    logic          sense_gate;
    logic          freeze;
    logic [CW-1:0] seq_count;
    logic          test_active;
    logic          lin_test;
    logic          unif_test;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    scan_sync_ctrl #(.GATE_CYCLES(GATE)) u_scan_sync_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_in     (start_in),
        .pause_in     (pause_in),
        .pause_strobe (pause_strobe),
        .test_ctl     (test_ctl),
        .sense_gate   (sense_gate),
        .freeze       (freeze),
        .seq_count    (seq_count),
        .test_active  (test_active),
        .lin_test     (lin_test),
        .unif_test    (unif_test)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic half();
        @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        start_in     = 1'b1;
        pause_in     = 1'b0;
        pause_strobe = 1'b0;
        test_ctl     = 3'b001;
        repeat (3) tick();
        chk("R10 gate", int'(sense_gate), 0);
        chk("R10 freeze", int'(freeze), 0);
        chk("R10 count", int'(seq_count), 0);
        rst_n = 1'b1;
        repeat (4) tick();

        // decode table walk (R9)
        for (int i = 0; i < 8; i++) begin
            test_ctl = DEC_TAB[i][5:3];
            #1;
            chk("R9 decode", int'({test_active, lin_test, unif_test}), int'(DEC_TAB[i][2:0]));
        end
        test_ctl = 3'b001;

        // R1 / R2: plain gate window
        start_in = 1'b0;
        tick(); chk("R1 k", int'(sense_gate), 0);
        tick(); chk("R1 k+1", int'(sense_gate), 0);
        tick(); chk("R1 k+2", int'(sense_gate), 0);
        tick(); chk("R1 k+3", int'(sense_gate), 1);
        chk("R1 count", int'(seq_count), 0);
        for (int i = 1; i < GATE; i++) begin
            tick();
            chk("R2 gate", int'(sense_gate), 1);
            chk("R2 count", int'(seq_count), i);
        end
        tick(); chk("R2 end gate", int'(sense_gate), 0);
        chk("R2 end count", int'(seq_count), 0);

        // R3: fall during an active window is ignored
        start_in = 1'b1;
        repeat (3) tick();
        start_in = 1'b0;
        repeat (4) tick();
        chk("R3 open", int'(sense_gate), 1);
        for (int i = 1; i <= GATE; i++) begin
            if (i == 1) start_in = 1'b1;
            if (i == 3) start_in = 1'b0;
            tick();
        end
        chk("R3 closed", int'(sense_gate), 0);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R3 no rerun", int'(sense_gate), 0);
        end
        start_in = 1'b1;

        // R5: pause without strobe
        pause_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(); half();
            chk("R5 idle", int'(freeze), 0);
        end
        pause_in = 1'b0;

        // R4: qualified pause, half-cycle timing
        pause_strobe = 1'b1;
        tick();
        pause_strobe = 1'b0;
        pause_in = 1'b1;
        tick();
        tick(); chk("R4 j+2", int'(freeze), 0);
        tick(); chk("R4 j+3 rise", int'(freeze), 0);
        half(); chk("R4 j+3 fall", int'(freeze), 1);

        // R8: start fall while frozen; R5 while frozen
        start_in = 1'b0;
        pause_in = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R8 held", int'(sense_gate), 0);
            chk("R5 frozen", int'(freeze), 1);
        end
        pause_in = 1'b1;
        tick();

        // R6 release, then R8 launch
        pause_strobe = 1'b1;
        tick();
        pause_strobe = 1'b0;
        pause_in = 1'b0;
        tick();
        tick();
        tick(); chk("R6 j+3 rise", int'(freeze), 1);
        half(); chk("R6 j+3 fall", int'(freeze), 0);
        tick(); chk("R8 r+1", int'(sense_gate), 0);
        tick(); chk("R8 r+2", int'(sense_gate), 1);
        chk("R8 count", int'(seq_count), 0);

        // R7: freeze in the middle of a window
        pause_strobe = 1'b1;
        tick();
        pause_strobe = 1'b0;
        pause_in = 1'b1;
        tick(); tick(); tick();
        chk("R7 pre count", int'(seq_count), 4);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R7 hold count", int'(seq_count), 4);
            chk("R7 hold gate", int'(sense_gate), 1);
        end
        pause_strobe = 1'b1;
        tick();
        pause_strobe = 1'b0;
        pause_in = 1'b0;
        tick(); tick(); tick();
        chk("R7 still held", int'(seq_count), 4);
        tick(); chk("R7 resume", int'(seq_count), 5);
        tick(); tick();
        chk("R7 last", int'(seq_count), 7);
        tick(); chk("R7 closed", int'(sense_gate), 0);

        summary();
        $finish;
    end
endmodule